// File: doc/BRIEF.md
# Masked Vector Lane Extract Unit

This datapath unit copies one lane-aligned slice of a wide source vector into the low end of a destination word. The source is either two or four base lanes wide. The copied slice is one base lane or two base lanes wide. At the default parameters a base lane is 128 bits. An immediate byte picks which slice is copied. An optional per-element write mask applies to the copied slice at one of two element sizes. The element is a quarter or a half of a base lane, so 32 or 64 bits by default. Masked-off elements are either kept from the old destination or cleared.

The old destination value comes in on its own input. For a register destination, every bit above the copied slice is cleared. A memory-style destination allows merging only and keeps its upper part. It also reports a write strobe for each quarter-lane segment, which tells the memory side which segments to write. Malformed encodings raise an error flag and leave the destination unchanged. A short unmasked form is also supported. Results, strobes and the error flag appear one clock after the request, qualified by a valid output.

Top module: `vec_slice_extract`

## Requirements
- R1: For a one-lane copy from a two-lane source, imm[0] picks the lane: 0 gives lane 0 (bits LANE_W-1:0) and 1 gives lane 1.
- R2: For a one-lane copy from a four-lane source (src_wide=1), imm[1:0] picks lane 0 to 3, where lane n occupies bits (n+1)*LANE_W-1 : n*LANE_W.
- R3: A two-lane copy (wide_out=1) takes the lower half of the source when imm[0]=0 and the upper half when imm[0]=1. A two-lane copy requested with src_wide=0 is an illegal encoding and sets out_err.
- R4: Immediate bits above the selector are ignored. That is imm[7:1] for a two-lane source or a two-lane copy, and imm[7:2] for a one-lane copy from a four-lane source.
- R5: With mask_en=1, mask bit j governs element j of the copied slice. Elements are quarter-lane when elem64=0 and half-lane when elem64=1. With mask_en=0, every element of the slice is written.
- R6: For a register destination (to_mem=0), a masked-off element keeps its old_dst value when zero_mode=0 and becomes zero when zero_mode=1.
- R7: For a register destination, every out_data bit above the copied slice width is zero, up to DST_W.
- R8: For a memory destination (to_mem=1), zero_mode is ignored and masked-off elements keep old_dst. Bits above the slice keep old_dst. out_we bit g is set exactly for each quarter-lane segment g of the slice that is written; out_we is all zero for a register destination.
- R9: out_err is set whenever vreg_field is not 4'b1111.
- R10: With legacy=1, the unit does a one-lane copy from a two-lane source chosen by imm[0], with no masking. It ignores src_wide, wide_out, mask_en and mask. It sets out_err when len_bit is 0.
- R11: When out_err is set, out_data equals the old_dst value that came with the request, and out_we is all zero.
- R12: Outputs are registered. out_valid follows in_valid one clock later. out_data, out_we and out_err update only for a valid request. A synchronous active-low reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid |
| src_wide | input | 1 | 1: source is four lanes, 0: two lanes |
| wide_out | input | 1 | 1: copy two lanes, 0: copy one lane |
| elem64 | input | 1 | 1: half-lane elements, 0: quarter-lane elements |
| mask_en | input | 1 | Apply the write mask |
| zero_mode | input | 1 | Masked-off elements cleared (register destination only) |
| to_mem | input | 1 | Memory-style destination |
| legacy | input | 1 | Short unmasked form |
| len_bit | input | 1 | Vector-length bit of the short form |
| vreg_field | input | 4 | Reserved register field, must be 1111 |
| imm | input | 8 | Slice selector immediate |
| mask | input | 8 | Per-element write mask |
| src | input | 4*LANE_W | Source vector |
| old_dst | input | DST_W | Previous destination value |
| out_valid | output | 1 | Result valid |
| out_data | output | DST_W | Result |
| out_we | output | DST_W*4/LANE_W | Per-segment write strobes for the memory path |
| out_err | output | 1 | Undefined-operation error |

## Verification
The bench builds the unit with LANE_W=16 and DST_W=64. That gives 4-bit quarter-lane segments, a 64-bit source and 16 strobe bits. At this size every combination of the six mode inputs can be swept. The sweep covers immediates with high bits set and a spread of masks, including all-zero, all-one, single-bit and alternating patterns. Both element sizes therefore meet every mask bit position, at every slice offset and for both destination kinds. Directed passes cover the reserved field, the short form and reset.

// File: rtl/vec_slice_extract.sv
module vec_slice_extract #(
  parameter int LANE_W = 128,
  parameter int DST_W  = 512
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      src_wide,
  input  logic                      wide_out,
  input  logic                      elem64,
  input  logic                      mask_en,
  input  logic                      zero_mode,
  input  logic                      to_mem,
  input  logic                      legacy,
  input  logic                      len_bit,
  input  logic [3:0]                vreg_field,
  input  logic [7:0]                imm,
  input  logic [7:0]                mask,
  input  logic [4*LANE_W-1:0]       src,
  input  logic [DST_W-1:0]          old_dst,
  output logic                      out_valid,
  output logic [DST_W-1:0]          out_data,
  output logic [DST_W*4/LANE_W-1:0] out_we,
  output logic                      out_err
);
  localparam int SRC_W = 4 * LANE_W;
  localparam int SEG_W = LANE_W / 4;
  localparam int NSEG  = DST_W / SEG_W;

  logic             w_src, w_out, m_on, z_on, bad;
  logic [1:0]       sel;
  logic [SRC_W-1:0] picked;
  logic [DST_W-1:0] nxt_data;
  logic [NSEG-1:0]  nxt_we;

  assign w_src = !legacy && src_wide;
  assign w_out = !legacy && wide_out;
  assign m_on  = !legacy && mask_en;
  assign z_on  = zero_mode && !to_mem;
  assign bad   = (vreg_field != 4'hF) || (legacy && !len_bit) || (!legacy && wide_out && !src_wide);
  assign sel   = (w_src && !w_out) ? imm[1:0] : {1'b0, imm[0]};
  assign picked = w_out ? (src >> (sel * 2 * LANE_W)) : (src >> (sel * LANE_W));

  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : seg
      logic [SEG_W-1:0] keep;
      assign keep = old_dst[g*SEG_W +: SEG_W];
      if (g < 8) begin : low
        logic in_ext, mbit, on;
        assign in_ext = (g < 4) || w_out;
        assign mbit   = elem64 ? mask[g/2] : mask[g];
        assign on     = !m_on || mbit;
        assign nxt_data[g*SEG_W +: SEG_W] =
          bad     ? keep :
          !in_ext ? (to_mem ? keep : '0) :
          on      ? picked[g*SEG_W +: SEG_W] :
          z_on    ? '0 : keep;
        assign nxt_we[g] = !bad && to_mem && in_ext && on;
      end else begin : high
        assign nxt_data[g*SEG_W +: SEG_W] = (bad || to_mem) ? keep : '0;
        assign nxt_we[g] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_we    <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= nxt_data;
        out_we   <= nxt_we;
        out_err  <= bad;
      end
    end
  end

  assert_valid_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));
  assert_bad_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vreg_field != 4'hF) |=> out_err);
  assert_err_keeps_dst_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vreg_field != 4'hF) |=> (out_data == $past(old_dst) && out_we == '0));
  assert_legacy_short_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legacy && !len_bit) |=> out_err);
  assert_reg_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !to_mem) |=> (out_err || out_data[DST_W-1:2*LANE_W] == '0));
  assert_mem_upper_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && to_mem) |=> (out_data[DST_W-1:2*LANE_W] == $past(old_dst[DST_W-1:2*LANE_W])));
  assert_reg_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !to_mem) |=> (out_we == '0));
  generate
    if (NSEG > 8) begin : hi_chk
      assert_no_high_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_we[NSEG-1:8] == '0));
    end
  endgenerate
endmodule

// File: tb/vec_slice_extract_bench.sv
module vec_slice_extract_bench;
  localparam int L = 16;
  localparam int D = 64;
  localparam int Q = L / 4;
  localparam int NS = D / Q;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, src_wide = 0, wide_out = 0, elem64 = 0, mask_en = 0;
  logic zero_mode = 0, to_mem = 0, legacy = 0, len_bit = 1;
  logic [3:0] vreg_field = 4'hF;
  logic [7:0] imm = 0, mask = 0;
  logic [4*L-1:0] src = 0;
  logic [D-1:0] old_dst = 0;
  logic out_valid, out_err;
  logic [D-1:0] out_data;
  logic [NS-1:0] out_we;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  vec_slice_extract #(.LANE_W(L), .DST_W(D)) u_vec_slice_extract (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_wide(src_wide),
    .wide_out(wide_out), .elem64(elem64), .mask_en(mask_en), .zero_mode(zero_mode),
    .to_mem(to_mem), .legacy(legacy), .len_bit(len_bit), .vreg_field(vreg_field),
    .imm(imm), .mask(mask), .src(src), .old_dst(old_dst), .out_valid(out_valid),
    .out_data(out_data), .out_we(out_we), .out_err(out_err));

  logic [D-1:0]  e_data;
  logic [NS-1:0] e_we;
  logic          e_err;

  task automatic model();
    logic sw, wo, me, ext, on;
    int sel, base;
    sw = legacy ? 1'b0 : src_wide;
    wo = legacy ? 1'b0 : wide_out;
    me = legacy ? 1'b0 : mask_en;
    e_err = (vreg_field != 4'hF) || (legacy && !len_bit) || (!legacy && wide_out && !src_wide);
    sel = (sw && !wo) ? int'(imm[1:0]) : int'(imm[0]);
    base = wo ? sel * 8 : sel * 4;
    e_we = '0;
    e_data = old_dst;
    if (!e_err) begin
      for (int g = 0; g < NS; g++) begin
        ext = (g < 4) || (wo && g < 8);
        if (!ext) begin
          if (!to_mem) e_data[g*Q +: Q] = '0;
        end else begin
          on = !me || mask[elem64 ? g / 2 : g];
          if (on) begin
            e_data[g*Q +: Q] = src[(base + g)*Q +: Q];
            e_we[g] = to_mem;
          end else if (zero_mode && !to_mem) begin
            e_data[g*Q +: Q] = '0;
          end
        end
      end
    end
  endtask

  function automatic string tag_of();
    if (wide_out && !src_wide) return "R3";
    if (to_mem) return "R8";
    if ((src_wide && !wide_out) ? (imm[7:2] != 0) : (imm[7:1] != 0)) return "R4";
    if (mask_en && zero_mode) return "R6";
    if (mask_en) return "R5";
    if (wide_out) return "R3";
    if (src_wide) return "R2";
    return "R1";
  endfunction

  task automatic check(string tag, logic ok, logic [D+NS:0] act, logic [D+NS:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(string tag);
    @(negedge clk);
    src = {$urandom, $urandom};
    old_dst = {$urandom, $urandom};
    in_valid = 1;
    model();
    @(negedge clk);
    check(tag, out_valid && out_data == e_data && out_we == e_we && out_err == e_err,
          {out_err, out_we, out_data}, {e_err, e_we, e_data});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] imms [8];
    logic [7:0] masks [16];
    imms = '{8'h00, 8'h01, 8'h02, 8'h03, 8'hFE, 8'h55, 8'hAA, 8'hFF};
    masks = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40,
              8'h80, 8'h5A, 8'hA5, 8'hFF, 8'h0F, 8'hF0, 8'h33, 8'hCC};
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", !out_valid && out_data == 0 && out_we == 0 && !out_err,
          {out_err, out_we, out_data}, '0);
    rst_n = 1;
    for (int c = 0; c < 64; c++) begin
      {src_wide, wide_out, elem64, mask_en, zero_mode, to_mem} = 6'(c);
      for (int i = 0; i < 8; i++) begin
        for (int m = 0; m < 16; m++) begin
          imm = imms[i];
          mask = masks[m];
          do_op(tag_of());
        end
      end
    end
    // R7: register destination upper bits cleared for one-lane copies
    {src_wide, wide_out, mask_en, to_mem} = 4'b1000;
    for (int i = 0; i < 4; i++) begin
      imm = 8'(i);
      do_op("R7");
      check("R7", out_data[D-1:L] == 0, {1'b0, 16'h0, out_data}, '0);
    end
    // R9 and R11: reserved field not all ones
    for (int v = 0; v < 15; v++) begin
      vreg_field = 4'(v);
      to_mem = v[0];
      do_op("R9");
      check("R11", out_err && out_data == old_dst && out_we == 0,
            {out_err, out_we, out_data}, {1'b1, 16'h0, old_dst});
    end
    vreg_field = 4'hF;
    // R10: short form, all other modes ignored
    legacy = 1;
    for (int c = 0; c < 64; c++) begin
      {src_wide, wide_out, mask_en, zero_mode, to_mem, len_bit} = 6'(c);
      for (int i = 0; i < 4; i++) begin
        imm = imms[i + 4];
        mask = masks[i];
        do_op("R10");
      end
    end
    legacy = 0;
    len_bit = 1;
    // R12: idle cycle holds result and drops valid
    {src_wide, wide_out, mask_en, to_mem} = 4'b1000;
    do_op("R12");
    @(negedge clk);
    in_valid = 0;
    src = ~src;
    @(negedge clk);
    check("R12", !out_valid && out_data == e_data, {1'b0, 16'h0, out_data}, {1'b0, 16'h0, e_data});
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule